// File: doc/BRIEF.md
# Match-Event Timer Core

This block is a 32-bit up-counter that sits under a bank of sixteen compare slots. Each slot holds a live match value and a shadow reload value. Sixteen events each pick one of the match values. In any counter tick where the counter equals the picked value, the event raises a one-clock pulse on a 16-bit event vector. Output logic downstream can use those pulses to set or clear pins, for example to build pulse-width modulated waveforms.

The period is not a fixed terminal count. A restart mask names the events that send the counter back to zero on its next tick, so a restart event at value N−1 gives a period of N ticks. At each such restart every match value is refreshed from its reload value, unless refresh is turned off. An 8-bit prescaler divides the clock by its value plus one. Software programs the block through a word-wide register bus with a combinational read port. The block leaves reset halted and with every event disabled.

Top module: `mte_timer`

## Requirements
- R1: After reset the control word reads 0x0000_0004 (halt set), every other mapped register reads 0, and the event vector stays 0.
- R2: Register map (byte offsets, word access): configuration 0x000 (bit 0 one-counter select, bit 7 reload inhibit), control 0x004 (bit 2 halt, bit 4 two-way count, bits 12:5 prescale), restart mask 0x008 (bits 15:0), match n at 0x100+4n, reload n at 0x200+4n, state mask n at 0x300+8n, event control n at 0x304+8n (bits 3:0 slot select, bits 13:12 combine mode). Reads return the stored fields, and unstored bits read 0.
- R3: Event n pulses in a counter tick only when all three hold: its state mask is 0xFFFF_FFFF, its combine mode is 1, and the counter equals the match value of its selected slot. A state mask with any bit clear, or any other combine mode, keeps the event at 0.
- R4: When an event whose restart-mask bit is set pulses, the counter is 0 after that tick. A match value of N−1 on that event therefore repeats its pulse every N ticks. Without a restart the counter steps by one and wraps after 0xFFFF_FFFF.
- R5: A tick occurs once every prescale+1 clocks. Event pulses last exactly one clock, in the tick clock.
- R6: The counter advances only while halt is 0, the one-counter select is 1 and two-way count is 0. Otherwise it holds, the prescaler is cleared, and no event pulses.
- R7: At a restart with reload inhibit clear, every match value takes its reload value. With reload inhibit set, match values are kept.
- R8: A bus write to a match register takes effect at once. If it falls in a restart tick, the written value wins over the reload value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Write strobe, captured at the rising edge |
| bus_addr | input | 12 | Byte address of the register accessed |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| evt_out | output | 16 | One-clock event pulses, bit n for event n |

## Verification
Two functions can fall in the same clock: the reload of match values at a counter restart, and a software write to a match register. The bench times a write to slot 0 into the exact restart clock of a running period of five. The new value must then set the next pulse position, giving a pulse three ticks into the next period. If the reload won instead, the pulse would come five ticks in. A restart pulse and the reload it triggers also coincide on every wrap, and the bench judges these by comparing period lengths before and after the reload value differs from the match value.

// File: rtl/mte_pkg.sv
package mte_pkg;

    localparam int NUM_EV  = 16;
    localparam int CNT_W   = 32;
    localparam int PRE_W   = 8;
    localparam int DATA_W  = 32;
    localparam int ADDR_W  = 12;
    localparam int IDX_W   = $clog2(NUM_EV);

    localparam int CFG_UNIFY_BIT    = 0;
    localparam int CFG_NORELOAD_BIT = 7;
    localparam int CTRL_HALT_BIT    = 2;
    localparam int CTRL_BIDIR_BIT   = 4;
    localparam int CTRL_PRE_LSB     = 5;
    localparam int EV_SEL_LSB       = 0;
    localparam int EV_COMB_LSB      = 12;

    localparam logic [1:0] COMB_MATCH = 2'd1;

    typedef struct packed {
        logic noreload;
        logic unify;
    } cfg_t;

    typedef struct packed {
        logic [PRE_W-1:0] presc;
        logic             bidir;
        logic             halt;
    } ctrl_t;

    typedef struct packed {
        logic [1:0]       comb;
        logic [IDX_W-1:0] sel;
    } evctl_t;

    localparam ctrl_t CTRL_RESET = '{presc: '0, bidir: 1'b0, halt: 1'b1};

    typedef enum logic [2:0] {
        RG_CFG, RG_CTRL, RG_LIMIT, RG_MATCH,
        RG_RELOAD, RG_SMASK, RG_EVCTL, RG_NONE
    } reg_kind_e;

    typedef struct packed {
        reg_kind_e        kind;
        logic [IDX_W-1:0] idx;
    } reg_hit_t;

    function automatic reg_hit_t mte_decode(input logic [ADDR_W-1:0] a);
        reg_hit_t h;
        h.kind = RG_NONE;
        h.idx  = '0;
        if (a[1:0] == 2'b00) begin
            case (a[11:8])
                4'h0: begin
                    case (a[7:2])
                        6'd0:    h.kind = RG_CFG;
                        6'd1:    h.kind = RG_CTRL;
                        6'd2:    h.kind = RG_LIMIT;
                        default: h.kind = RG_NONE;
                    endcase
                end
                4'h1, 4'h2: begin
                    if ((a[7:2] >> IDX_W) == 6'd0) begin
                        h.kind = (a[11:8] == 4'h1) ? RG_MATCH : RG_RELOAD;
                        h.idx  = a[2 +: IDX_W];
                    end
                end
                4'h3: begin
                    if ((a[7:3] >> IDX_W) == 5'd0) begin
                        h.kind = a[2] ? RG_EVCTL : RG_SMASK;
                        h.idx  = a[3 +: IDX_W];
                    end
                end
                default: h.kind = RG_NONE;
            endcase
        end
        return h;
    endfunction

    function automatic logic [DATA_W-1:0] cfg_to_word(input cfg_t c);
        logic [DATA_W-1:0] w;
        w = '0;
        w[CFG_UNIFY_BIT]    = c.unify;
        w[CFG_NORELOAD_BIT] = c.noreload;
        return w;
    endfunction

    function automatic logic [DATA_W-1:0] ctrl_to_word(input ctrl_t c);
        logic [DATA_W-1:0] w;
        w = '0;
        w[CTRL_HALT_BIT]               = c.halt;
        w[CTRL_BIDIR_BIT]              = c.bidir;
        w[CTRL_PRE_LSB +: PRE_W]       = c.presc;
        return w;
    endfunction

    function automatic logic [DATA_W-1:0] evctl_to_word(input evctl_t e);
        logic [DATA_W-1:0] w;
        w = '0;
        w[EV_SEL_LSB +: IDX_W] = e.sel;
        w[EV_COMB_LSB +: 2]    = e.comb;
        return w;
    endfunction

endpackage

// File: rtl/mte_regs.sv
module mte_regs
    import mte_pkg::*;
(
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         we,
    input  logic [ADDR_W-1:0]            addr,
    input  logic [DATA_W-1:0]            wdata,
    input  logic                         restart,
    output logic [DATA_W-1:0]            rdata,
    output cfg_t                         cfg,
    output ctrl_t                        ctrl,
    output logic [NUM_EV-1:0]            limit,
    output logic [NUM_EV-1:0][CNT_W-1:0] match,
    output evctl_t [NUM_EV-1:0]          evctl,
    output logic [NUM_EV-1:0]            live
);

    cfg_t                         cfg_q;
    ctrl_t                        ctrl_q;
    logic [NUM_EV-1:0]            limit_q;
    logic [NUM_EV-1:0][CNT_W-1:0] match_q;
    logic [NUM_EV-1:0][CNT_W-1:0] rel_q;
    logic [NUM_EV-1:0][DATA_W-1:0] smask_q;
    evctl_t [NUM_EV-1:0]          evctl_q;
    reg_hit_t                     hit;

    always_comb hit = mte_decode(addr);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q   <= '0;
            ctrl_q  <= CTRL_RESET;
            limit_q <= '0;
            rel_q   <= '0;
            smask_q <= '0;
            evctl_q <= '0;
        end else if (we) begin
            case (hit.kind)
                RG_CFG: begin
                    cfg_q.unify    <= wdata[CFG_UNIFY_BIT];
                    cfg_q.noreload <= wdata[CFG_NORELOAD_BIT];
                end
                RG_CTRL: begin
                    ctrl_q.halt  <= wdata[CTRL_HALT_BIT];
                    ctrl_q.bidir <= wdata[CTRL_BIDIR_BIT];
                    ctrl_q.presc <= wdata[CTRL_PRE_LSB +: PRE_W];
                end
                RG_LIMIT:  limit_q <= wdata[NUM_EV-1:0];
                RG_RELOAD: rel_q[hit.idx] <= wdata[CNT_W-1:0];
                RG_SMASK:  smask_q[hit.idx] <= wdata;
                RG_EVCTL: begin
                    evctl_q[hit.idx].sel  <= wdata[EV_SEL_LSB +: IDX_W];
                    evctl_q[hit.idx].comb <= wdata[EV_COMB_LSB +: 2];
                end
                default: ;
            endcase
        end
    end

    // Live match slots: a bus write beats the restart reload.
    for (genvar k = 0; k < NUM_EV; k++) begin : g_slot
        logic wr_hit;
        assign wr_hit = we && (hit.kind == RG_MATCH) && (hit.idx == IDX_W'(k));

        always_ff @(posedge clk) begin
            if (rst)
                match_q[k] <= '0;
            else if (wr_hit)
                match_q[k] <= wdata[CNT_W-1:0];
            else if (restart && !cfg_q.noreload)
                match_q[k] <= rel_q[k];
        end

        assign live[k] = &smask_q[k];
    end

    always_comb begin
        case (hit.kind)
            RG_CFG:    rdata = cfg_to_word(cfg_q);
            RG_CTRL:   rdata = ctrl_to_word(ctrl_q);
            RG_LIMIT:  rdata = DATA_W'(limit_q);
            RG_MATCH:  rdata = DATA_W'(match_q[hit.idx]);
            RG_RELOAD: rdata = DATA_W'(rel_q[hit.idx]);
            RG_SMASK:  rdata = smask_q[hit.idx];
            RG_EVCTL:  rdata = evctl_to_word(evctl_q[hit.idx]);
            default:   rdata = '0;
        endcase
    end

    assign cfg   = cfg_q;
    assign ctrl  = ctrl_q;
    assign limit = limit_q;
    assign match = match_q;
    assign evctl = evctl_q;

    assert_reload_copy_R7: assert property (@(posedge clk) disable iff (rst)
        (restart && !cfg_q.noreload && !(we && hit.kind == RG_MATCH))
        |=> match_q[0] == $past(rel_q[0]));

    assert_reload_inhibit_R7: assert property (@(posedge clk) disable iff (rst)
        (restart && cfg_q.noreload && !(we && hit.kind == RG_MATCH))
        |=> $stable(match_q[0]));

    assert_write_wins_R8: assert property (@(posedge clk) disable iff (rst)
        (we && hit.kind == RG_MATCH && hit.idx == '0)
        |=> match_q[0] == $past(wdata[CNT_W-1:0]));

endmodule

// File: rtl/mte_prescale_count.sv
module mte_prescale_count
    import mte_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [PRE_W-1:0] presc,
    input  logic             restart,
    output logic             tick,
    output logic [CNT_W-1:0] cnt
);

    logic [PRE_W-1:0] pre_q;
    logic [CNT_W-1:0] cnt_q;

    assign tick = run && (pre_q == presc);

    always_ff @(posedge clk) begin
        if (rst || !run)
            pre_q <= '0;
        else if (tick)
            pre_q <= '0;
        else
            pre_q <= pre_q + PRE_W'(1);
    end

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (tick)
            cnt_q <= restart ? '0 : cnt_q + CNT_W'(1);
    end

    assign cnt = cnt_q;

    assert_hold_stopped_R6: assert property (@(posedge clk) disable iff (rst)
        !run |=> $stable(cnt_q));

    assert_restart_zero_R4: assert property (@(posedge clk) disable iff (rst)
        (tick && restart) |=> cnt_q == '0);

    assert_step_one_R4: assert property (@(posedge clk) disable iff (rst)
        (tick && !restart) |=> cnt_q == $past(cnt_q) + CNT_W'(1));

    assert_tick_gap_R5: assert property (@(posedge clk) disable iff (rst)
        (tick && presc != '0) |=> (!tick || presc == '0));

endmodule

// File: rtl/mte_match.sv
module mte_match
    import mte_pkg::*;
(
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         tick,
    input  logic [CNT_W-1:0]             cnt,
    input  logic [NUM_EV-1:0][CNT_W-1:0] match,
    input  evctl_t [NUM_EV-1:0]          evctl,
    input  logic [NUM_EV-1:0]            live,
    output logic [NUM_EV-1:0]            fire
);

    for (genvar i = 0; i < NUM_EV; i++) begin : g_ev
        logic [CNT_W-1:0] picked;
        logic             armed;
        assign picked  = match[evctl[i].sel];
        assign armed   = live[i] && (evctl[i].comb == COMB_MATCH);
        assign fire[i] = tick && armed && (cnt == picked);
    end

    assert_fire_on_tick_R5: assert property (@(posedge clk) disable iff (rst)
        (|fire) |-> tick);

    assert_fire_armed_R3: assert property (@(posedge clk) disable iff (rst)
        fire[0] |-> (live[0] && evctl[0].comb == COMB_MATCH));

endmodule

// File: rtl/mte_timer.sv
module mte_timer
    import mte_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [NUM_EV-1:0] evt_out
);

    cfg_t                         cfg;
    ctrl_t                        ctrl;
    logic [NUM_EV-1:0]            limit;
    logic [NUM_EV-1:0][CNT_W-1:0] match;
    evctl_t [NUM_EV-1:0]          evctl;
    logic [NUM_EV-1:0]            live;
    logic [NUM_EV-1:0]            fire;
    logic                         run;
    logic                         tick;
    logic                         restart;
    logic [CNT_W-1:0]             cnt;

    assign run     = !ctrl.halt && cfg.unify && !ctrl.bidir;
    assign restart = tick && |(fire & limit);
    assign evt_out = fire;

    mte_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .we      (bus_we),
        .addr    (bus_addr),
        .wdata   (bus_wdata),
        .restart (restart),
        .rdata   (bus_rdata),
        .cfg     (cfg),
        .ctrl    (ctrl),
        .limit   (limit),
        .match   (match),
        .evctl   (evctl),
        .live    (live)
    );

    mte_prescale_count u_count (
        .clk     (clk),
        .rst     (rst),
        .run     (run),
        .presc   (ctrl.presc),
        .restart (restart),
        .tick    (tick),
        .cnt     (cnt)
    );

    mte_match u_match (
        .clk   (clk),
        .rst   (rst),
        .tick  (tick),
        .cnt   (cnt),
        .match (match),
        .evctl (evctl),
        .live  (live),
        .fire  (fire)
    );

    assert_quiet_stopped_R6: assert property (@(posedge clk) disable iff (rst)
        !run |-> evt_out == '0);

endmodule

// File: tb/sim_mte_timer.sv
module sim_mte_timer;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_we = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    wire  [31:0] bus_rdata;
    wire  [15:0] evt_out;

    int checks = 0;
    int errors = 0;

    typedef struct {
        logic [15:0] v;
        string       tag;
    } item_t;
    item_t sb[$];

    int unsigned m_match[16];
    int unsigned m_rel[16];
    int          m_sel[16];
    bit          m_en[16];

    mte_timer u0 (
        .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .evt_out(evt_out)
    );

    always #2 clk = ~clk;

    // Monitor: one expected vector per clock while the queue holds items.
    always @(negedge clk) begin
        if (sb.size() > 0) begin
            item_t it;
            it = sb.pop_front();
            checks++;
            if (evt_out !== it.v) begin
                errors++;
                $display("FAIL %s: evt_out actual %h expected %h", it.tag, evt_out, it.v);
            end
        end
    end

    initial begin
        #400000;
        errors++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    task automatic bus_wr(input int unsigned a, input logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a[11:0]; bus_wdata = d;
        @(posedge clk);
        #1 bus_we = 1'b0;
    endtask

    task automatic rd_chk(input int unsigned a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        bus_addr = a[11:0];
        #1;
        checks++;
        if (bus_rdata !== exp) begin
            errors++;
            $display("FAIL %s: read %h actual %h expected %h", tag, a, bus_rdata, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        for (int i = 0; i < 16; i++) begin
            m_match[i] = 0; m_rel[i] = 0; m_sel[i] = 0; m_en[i] = 1'b0;
        end
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic program_ev(input int i, input int sel, input int unsigned mv,
                              input int unsigned rv, input logic [31:0] mask, input int comb);
        bus_wr(32'h100 + 4*i, mv);
        bus_wr(32'h200 + 4*i, rv);
        bus_wr(32'h300 + 8*i, mask);
        bus_wr(32'h304 + 8*i, sel | (comb << 12));
        m_match[i] = mv; m_rel[i] = rv; m_sel[i] = sel;
        m_en[i] = (mask == 32'hFFFF_FFFF) && (comb == 1);
    endtask

    task automatic push_idle(input int n, input string tag);
        item_t it;
        for (int k = 0; k < n; k++) begin
            it.v = '0; it.tag = tag;
            sb.push_back(it);
        end
    endtask

    // Expected pulses computed from the requirements, cycle 0 = first clock after release.
    task automatic push_model(input int ncyc, input int presc, input bit nr, input logic [15:0] lim,
                              input int wr_cyc, input int wr_idx, input int unsigned wr_val,
                              input string tag);
        int unsigned mm[16];
        int unsigned cnt = 0;
        int          pre = 0;
        item_t       it;
        for (int i = 0; i < 16; i++) mm[i] = m_match[i];
        for (int k = 0; k < ncyc; k++) begin
            bit tk;
            bit rs;
            tk = (pre == presc);
            it.v = '0; it.tag = tag;
            if (tk)
                for (int i = 0; i < 16; i++)
                    if (m_en[i] && cnt == mm[m_sel[i]]) it.v[i] = 1'b1;
            rs = tk && ((it.v & lim) != 0);
            sb.push_back(it);
            if (rs && !nr) for (int i = 0; i < 16; i++) mm[i] = m_rel[i];
            if (k == wr_cyc) mm[wr_idx] = wr_val;
            pre = tk ? 0 : pre + 1;
            if (tk) cnt = rs ? 0 : cnt + 1;
        end
    endtask

    task automatic go(input int ncyc, input int presc, input bit nr, input logic [15:0] lim,
                      input int wr_cyc, input int wr_idx, input int unsigned wr_val,
                      input string tag);
        bus_wr(32'h000, 32'h1 | (nr << 7));
        bus_wr(32'h008, {16'h0, lim});
        bus_wr(32'h004, presc << 5);
        push_model(ncyc, presc, nr, lim, wr_cyc, wr_idx, wr_val, tag);
        if (wr_cyc >= 0) begin
            repeat (wr_cyc) @(posedge clk);
            #1;
            bus_we = 1'b1; bus_addr = 12'h100 + 12'(4*wr_idx); bus_wdata = wr_val;
            @(posedge clk);
            #1 bus_we = 1'b0;
        end
        wait (sb.size() == 0);
        @(negedge clk);
    endtask

    initial begin
        // R1: reset values and quiet output
        do_reset();
        rd_chk(32'h004, 32'h0000_0004, "R1 ctrl");
        rd_chk(32'h000, 32'h0, "R1 cfg");
        rd_chk(32'h10C, 32'h0, "R1 match3");
        rd_chk(32'h304, 32'h0, "R1 evctl0");
        rd_chk(32'h300, 32'h0, "R1 smask0");
        push_idle(8, "R1 idle");
        wait (sb.size() == 0);

        // R2: readback and field masking
        bus_wr(32'h32C, 32'hFFFF_FFFF);
        rd_chk(32'h32C, 32'h0000_300F, "R2 evctl5");
        bus_wr(32'h004, 32'hFFFF_FFFF);
        rd_chk(32'h004, 32'h0000_1FF4, "R2 ctrl");
        bus_wr(32'h000, 32'hFFFF_FFFF);
        rd_chk(32'h000, 32'h0000_0081, "R2 cfg");
        bus_wr(32'h21C, 32'h1234_5678);
        rd_chk(32'h21C, 32'h1234_5678, "R2 reload7");
        bus_wr(32'h008, 32'hFFFF_FFFF);
        rd_chk(32'h008, 32'h0000_FFFF, "R2 limit");
        rd_chk(32'h03C, 32'h0, "R2 unmapped");

        // R3/R4: period 5, shared slot select, disabled events
        do_reset();
        program_ev(0, 0, 4, 4, 32'hFFFF_FFFF, 1);
        program_ev(1, 1, 2, 2, 32'hFFFF_FFFF, 1);
        program_ev(2, 1, 2, 2, 32'hFFFF_FFFE, 1);
        program_ev(3, 1, 2, 2, 32'hFFFF_FFFF, 2);
        program_ev(5, 1, 2, 2, 32'hFFFF_FFFF, 1);
        go(22, 0, 1'b0, 16'h0001, -1, 0, 0, "R3 R4 basic");

        // R5: prescale 2 divides by three
        do_reset();
        program_ev(0, 0, 4, 4, 32'hFFFF_FFFF, 1);
        program_ev(1, 1, 1, 1, 32'hFFFF_FFFF, 1);
        go(40, 2, 1'b0, 16'h0001, -1, 0, 0, "R5 prescale");

        // R7: reload applied at restart
        do_reset();
        program_ev(0, 0, 4, 6, 32'hFFFF_FFFF, 1);
        program_ev(1, 1, 2, 2, 32'hFFFF_FFFF, 1);
        go(26, 0, 1'b0, 16'h0001, -1, 0, 0, "R7 reload");

        // R7: reload inhibited
        do_reset();
        program_ev(0, 0, 4, 6, 32'hFFFF_FFFF, 1);
        go(20, 0, 1'b1, 16'h0001, -1, 0, 0, "R7 inhibit");

        // R4: restart from a non-zero event
        do_reset();
        program_ev(0, 0, 4, 4, 32'hFFFF_FFFF, 1);
        program_ev(1, 1, 2, 2, 32'hFFFF_FFFF, 1);
        go(15, 0, 1'b0, 16'h0002, -1, 0, 0, "R4 limit ev1");

        // R6: no counting when halted, two-way set, or one-counter select clear
        do_reset();
        program_ev(0, 0, 0, 0, 32'hFFFF_FFFF, 1);
        bus_wr(32'h000, 32'h1);
        bus_wr(32'h004, 32'h10);
        push_idle(12, "R6 bidir");
        wait (sb.size() == 0);
        bus_wr(32'h000, 32'h0);
        bus_wr(32'h004, 32'h0);
        push_idle(12, "R6 unify");
        wait (sb.size() == 0);
        bus_wr(32'h000, 32'h1);
        bus_wr(32'h004, 32'h4);
        push_idle(12, "R6 halt");
        wait (sb.size() == 0);

        // R8: write to match0 in the restart clock beats the reload
        do_reset();
        program_ev(0, 0, 4, 4, 32'hFFFF_FFFF, 1);
        go(20, 0, 1'b0, 16'h0001, 4, 0, 2, "R8 collision");
        rd_chk(32'h100, 32'h4, "R8 reload after");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule